// File: doc/BRIEF.md
# IDE PIO strobe timing generator

This block produces the read and write strobes for one ATA/IDE channel during programmed-I/O cycles. All timing is counted in whole clock periods. A request port carries a direction bit and a drive-select bit. When the block accepts a request, it asserts the matching active-low strobe. After a programmable number of clocks, it samples the drive's ready line for the first time.

If the drive is not ready, the strobe stays low and the ready line is sampled again on every clock. When a sample finds the drive ready, the strobe is released and a one-clock `done_o` pulse is raised. For a read, that pulse marks the data-capture point. The block then enforces a recovery gap before it accepts the next request.

Each of the two drives has its own 2-bit sample-point code and 2-bit recovery code. These codes are inverted: code 0 is the slowest setting. The drive-select bit of the request chooses which pair applies, and the pair is captured when the request is accepted. If a drive holds the ready line low for too long, the block ends the cycle and pulses a timeout flag.

Top module: `ide_pio_strobe`

## Requirements
- R1: While `rst_ni` is low and on the first clock after it rises, both strobes are high, `busy_o`, `done_o` and `timeout_o` are low and `req_ready_o` is high.
- R2: The sample-point code maps to a strobe-low time of N clocks before the first ready sample: code 0 gives 5, code 1 gives 4, code 2 gives 3, code 3 gives 2. With the ready line high at the first sample, the strobe is low for exactly N clocks.
- R3: The recovery code maps to R clocks: code 0 gives 4, code 1 gives 3, code 2 gives 2, code 3 gives 1. After the strobe is released, `busy_o` stays high for R clocks. With back-to-back requests, the strobe stays high for exactly R+1 clocks.
- R4: `req_drive_i` = 0 selects the drive-0 codes and 1 selects the drive-1 codes. The codes and the drive are captured at acceptance, so later changes to them do not affect a cycle already in progress.
- R5: While the ready line is sampled low at or after the sample point, the strobe stays low. The strobe is released on the first clock edge that samples the ready line high.
- R6: A request with `req_write_i` = 1 drives only `wr_strobe_no` low, and a request with `req_write_i` = 0 drives only `rd_strobe_no` low. The two strobes are never low together.
- R7: `req_ready_o` is high only while the block is idle. A request is taken on a clock edge where both `req_valid_i` and `req_ready_o` are high, and the strobe falls on that edge. A `req_valid_i` raised while the block is busy starts no cycle.
- R8: `done_o` is a one-clock pulse. It is raised in the first clock in which the strobe is high again after a cycle.
- R9: After 256 consecutive low samples of the ready line, the cycle ends: the strobe is released and `timeout_o` pulses together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write cycle, 0 = read cycle |
| req_drive_i | input | 1 | Target drive (0 or 1) |
| req_ready_o | output | 1 | Request accepted this edge when valid is high |
| d0_sample_code_i | input | 2 | Drive 0 sample-point code |
| d0_recov_code_i | input | 2 | Drive 0 recovery code |
| d1_sample_code_i | input | 2 | Drive 1 sample-point code |
| d1_recov_code_i | input | 2 | Drive 1 recovery code |
| iordy_i | input | 1 | Drive ready, high = ready |
| rd_strobe_no | output | 1 | Read strobe, active low |
| wr_strobe_no | output | 1 | Write strobe, active low |
| busy_o | output | 1 | Cycle or recovery in progress |
| done_o | output | 1 | One-clock end-of-cycle pulse |
| timeout_o | output | 1 | One-clock pulse when the cycle was ended by the wait limit |

## Verification
The assertions assume that the ready line and the request inputs are synchronous to `clk_i` and stable around each rising edge. The stimulus meets this by changing every input only on the falling edge. The assertions also assume that the timing codes are valid 2-bit values, which holds for any 2-bit input. The stimulus keeps `req_valid_i` high only briefly while the block is busy, so that the ignored request is observed and not accepted later by accident. The stimulus also changes the timing codes in the middle of a cycle, to show that the values captured at acceptance are the ones that govern the cycle.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int CODE_W = 2;
  localparam int CNT_W  = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_RECOV  = 2'd2
  } pio_state_e;

  // inverted codes: 0 is slowest
  function automatic logic [CNT_W-1:0] sample_clks(input logic [CODE_W-1:0] code);
    return CNT_W'(5) - CNT_W'(code);
  endfunction

  function automatic logic [CNT_W-1:0] recov_clks(input logic [CODE_W-1:0] code);
    return CNT_W'(4) - CNT_W'(code);
  endfunction
endpackage

// File: rtl/ide_pio_timing_sel.sv
module ide_pio_timing_sel
  import ide_pio_pkg::*;
#(
  parameter int NUM_DRIVES = 2,
  localparam int SEL_W = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1
) (
  input  logic [SEL_W-1:0]                  drive_i,
  input  logic [NUM_DRIVES-1:0][CODE_W-1:0] sample_code_i,
  input  logic [NUM_DRIVES-1:0][CODE_W-1:0] recov_code_i,
  output logic [CNT_W-1:0]                  sample_clks_o,
  output logic [CNT_W-1:0]                  recov_clks_o
);
  logic [NUM_DRIVES-1:0][CNT_W-1:0] smp_dec;
  logic [NUM_DRIVES-1:0][CNT_W-1:0] rec_dec;

  for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
    assign smp_dec[g] = sample_clks(sample_code_i[g]);
    assign rec_dec[g] = recov_clks(recov_code_i[g]);
  end

  assign sample_clks_o = smp_dec[drive_i];
  assign recov_clks_o  = rec_dec[drive_i];
endmodule

// File: rtl/ide_pio_cycle_fsm.sv
module ide_pio_cycle_fsm
  import ide_pio_pkg::*;
#(
  parameter int WAIT_LIMIT = 256,
  localparam int WAIT_W = $clog2(WAIT_LIMIT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_write_i,
  output logic             req_ready_o,
  input  logic [CNT_W-1:0] sample_clks_i,
  input  logic [CNT_W-1:0] recov_clks_i,
  input  logic             iordy_i,
  output logic             rd_strobe_no,
  output logic             wr_strobe_no,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o
);
  pio_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  rec_q, rec_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;
  logic              wr_q, wr_d;
  logic              done_d, tmo_d;
  logic              rd_n_q, wr_n_q, done_q, tmo_q;
  logic              wait_full;

  assign wait_full = (wcnt_q == WAIT_W'(WAIT_LIMIT - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rec_d   = rec_q;
    wcnt_d  = wcnt_q;
    wr_d    = wr_q;
    done_d  = 1'b0;
    tmo_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        state_d = ST_STROBE;
        cnt_d   = sample_clks_i - CNT_W'(1);
        rec_d   = recov_clks_i;
        wcnt_d  = '0;
        wr_d    = req_write_i;
      end
      ST_STROBE: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
        end else if (iordy_i || wait_full) begin
          state_d = ST_RECOV;
          cnt_d   = rec_q - CNT_W'(1);
          done_d  = 1'b1;
          tmo_d   = !iordy_i;
        end else begin
          wcnt_d = wcnt_q + WAIT_W'(1);
        end
      end
      ST_RECOV: begin
        if (cnt_q != '0) cnt_d = cnt_q - CNT_W'(1);
        else             state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rec_q   <= '0;
      wcnt_q  <= '0;
      wr_q    <= 1'b0;
      rd_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
      done_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rec_q   <= rec_d;
      wcnt_q  <= wcnt_d;
      wr_q    <= wr_d;
      rd_n_q  <= !((state_d == ST_STROBE) && !wr_d);
      wr_n_q  <= !((state_d == ST_STROBE) && wr_d);
      done_q  <= done_d;
      tmo_q   <= tmo_d;
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign busy_o       = (state_q != ST_IDLE);
  assign rd_strobe_no = rd_n_q;
  assign wr_strobe_no = wr_n_q;
  assign done_o       = done_q;
  assign timeout_o    = tmo_q;

  logic strb_hi;
  assign strb_hi = rd_n_q && wr_n_q;

  AST_NO_DUAL_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_n_q || wr_n_q); // R6
  AST_ACCEPT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !strb_hi); // R7
  AST_STROBE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strb_hi) |=> !strb_hi); // R2
  AST_RECOV_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(strb_hi) |=> strb_hi); // R3
  AST_HOLD_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STROBE) && (cnt_q == '0) && !iordy_i && !wait_full |=> !strb_hi); // R5
  AST_DONE_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> strb_hi && $past(!strb_hi)); // R8
  AST_DONE_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_TMO_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> done_o); // R9
endmodule

// File: rtl/ide_pio_strobe.sv
module ide_pio_strobe
  import ide_pio_pkg::*;
#(
  parameter int WAIT_LIMIT = 256
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       req_write_i,
  input  logic       req_drive_i,
  output logic       req_ready_o,
  input  logic [1:0] d0_sample_code_i,
  input  logic [1:0] d0_recov_code_i,
  input  logic [1:0] d1_sample_code_i,
  input  logic [1:0] d1_recov_code_i,
  input  logic       iordy_i,
  output logic       rd_strobe_no,
  output logic       wr_strobe_no,
  output logic       busy_o,
  output logic       done_o,
  output logic       timeout_o
);
  logic [1:0][CODE_W-1:0] smp_codes, rec_codes;
  logic [CNT_W-1:0]       smp_clks, rec_clks;

  assign smp_codes = {d1_sample_code_i, d0_sample_code_i};
  assign rec_codes = {d1_recov_code_i,  d0_recov_code_i};

  ide_pio_timing_sel #(.NUM_DRIVES(2)) u_sel (
    .drive_i       (req_drive_i),
    .sample_code_i (smp_codes),
    .recov_code_i  (rec_codes),
    .sample_clks_o (smp_clks),
    .recov_clks_o  (rec_clks)
  );

  ide_pio_cycle_fsm #(.WAIT_LIMIT(WAIT_LIMIT)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_write_i   (req_write_i),
    .req_ready_o   (req_ready_o),
    .sample_clks_i (smp_clks),
    .recov_clks_i  (rec_clks),
    .iordy_i       (iordy_i),
    .rd_strobe_no  (rd_strobe_no),
    .wr_strobe_no  (wr_strobe_no),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .timeout_o     (timeout_o)
  );
endmodule

// File: tb/tb_ide_pio_strobe.sv
module tb_ide_pio_strobe;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_drive = 1'b0;
  logic req_ready;
  logic [1:0] d0_smp = 2'd0, d0_rec = 2'd0, d1_smp = 2'd0, d1_rec = 2'd0;
  logic iordy = 1'b1;
  logic rd_n, wr_n, busy, done, tmo;

  int n_cmp = 0, n_bad = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  ide_pio_strobe dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_drive_i(req_drive), .req_ready_o(req_ready),
    .d0_sample_code_i(d0_smp), .d0_recov_code_i(d0_rec),
    .d1_sample_code_i(d1_smp), .d1_recov_code_i(d1_rec),
    .iordy_i(iordy), .rd_strobe_no(rd_n), .wr_strobe_no(wr_n),
    .busy_o(busy), .done_o(done), .timeout_o(tmo)
  );

  // behavioural reference: phase 0 idle, 1 strobe, 2 recovery
  int m_phase = 0, m_ticks = 0, m_low = 0, m_rt = 0, m_n = 5, m_r = 4;
  bit m_wr = 0, m_done = 0, m_tmo = 0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_phase = 0; m_done = 0; m_tmo = 0; m_wr = 0;
    end else begin
      m_done = 0; m_tmo = 0;
      case (m_phase)
        0: if (req_valid) begin
          m_phase = 1; m_wr = req_write; m_ticks = 0; m_low = 0;
          m_n = 5 - int'(req_drive ? d1_smp : d0_smp);
          m_r = 4 - int'(req_drive ? d1_rec : d0_rec);
        end
        1: begin
          m_ticks++;
          if (m_ticks >= m_n) begin
            if (iordy) begin
              m_phase = 2; m_done = 1; m_rt = 0;
            end else begin
              m_low++;
              if (m_low == 256) begin
                m_phase = 2; m_done = 1; m_tmo = 1; m_rt = 0;
              end
            end
          end
        end
        default: begin
          m_rt++;
          if (m_rt == m_r) m_phase = 0;
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      logic [5:0] act, exp;
      act = {req_ready, busy, rd_n, wr_n, done, tmo};
      exp = {m_phase == 0, m_phase != 0, !(m_phase == 1 && !m_wr),
             !(m_phase == 1 && m_wr), m_done, m_tmo};
      n_cmp++;
      if (act !== exp) begin
        n_bad++;
        $display("FAIL %s t=%0t {ready,busy,rd_n,wr_n,done,tmo} actual=%b expected=%b",
                 cur_req, $time, act, exp);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one transfer; iordy low for the first 'hold' clocks; returns strobe-low clocks
  task automatic run_cycle(input bit drv, input bit wr, input int hold, output int width);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_drive = drv; req_write = wr;
    iordy = (hold == 0);
    width = 0;
    for (int i = 1; ; i++) begin
      @(negedge clk);
      req_valid = 0;
      if (i >= hold) iordy = 1;
      if (done) break;
      if (!(rd_n && wr_n)) width++;
    end
    iordy = 1;
  endtask

  // issue the next request as soon as allowed; return strobe-high clocks in between
  task automatic run_gap(input bit drv, output int gap);
    int w;
    gap = 1;
    req_valid = 1; req_drive = drv; req_write = 0;
    @(negedge clk);
    while (rd_n && wr_n) begin gap++; @(negedge clk); end
    req_valid = 0;
    while (!done) @(negedge clk);
    w = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int w, g;
    repeat (3) @(negedge clk);
    // R1 reset values
    check(rd_n && wr_n && !busy && !done && !tmo && req_ready, "R1 reset", 0, 0);
    rst_ni = 1;
    @(negedge clk);
    check(rd_n && wr_n && !busy && req_ready, "R1 after release", 0, 0);

    cur_req = "R2";
    for (int c = 0; c < 4; c++) begin
      d0_smp = 2'(c);
      run_cycle(0, 0, 0, w);
      check(w == 5 - c, "R2 sample width", w, 5 - c);
      idle(6);
    end

    cur_req = "R3";
    for (int c = 0; c < 4; c++) begin
      d0_rec = 2'(c);
      run_cycle(0, 0, 0, w);
      run_gap(0, g);
      check(g == 4 - c + 1, "R3 recovery gap", g, 5 - c);
      idle(6);
    end

    cur_req = "R4";
    d0_smp = 2'd3; d0_rec = 2'd3; d1_smp = 2'd0; d1_rec = 2'd0;
    run_cycle(1, 0, 0, w);
    check(w == 5, "R4 drive1 width", w, 5);
    idle(6);
    run_cycle(0, 1, 0, w);
    check(w == 2, "R4 drive0 width", w, 2);
    idle(6);
    // change codes during a cycle: captured values must rule
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_drive = 1; req_write = 0; iordy = 1;
    @(negedge clk);
    req_valid = 0; d1_smp = 2'd3; d1_rec = 2'd3; req_drive = 0;
    w = 1;
    @(negedge clk);
    while (!done) begin w++; @(negedge clk); end
    check(w == 5, "R4 codes latched", w, 5);
    idle(8);

    cur_req = "R5";
    d0_smp = 2'd2;
    run_cycle(0, 0, 9, w);
    check(w == 9, "R5 extended width", w, 9);
    idle(6);
    run_cycle(0, 0, 2, w);
    check(w == 3, "R5 early ready", w, 3);
    idle(6);

    cur_req = "R6";
    run_cycle(0, 1, 4, w);
    check(w == 4, "R6 write width", w, 4);
    idle(6);

    cur_req = "R7";
    run_cycle(0, 0, 0, w);
    req_valid = 1;  // recovery in progress: must be ignored
    @(negedge clk);
    req_valid = 0;
    idle(8);
    check(rd_n && wr_n && req_ready && !busy, "R7 no start while busy", 0, 0);

    cur_req = "R9";
    d0_smp = 2'd0;
    run_cycle(0, 1, 400, w);
    check(w == 5 + 255, "R9 timeout width", w, 260);
    idle(8);

    cur_req = "R8";
    for (int k = 0; k < 40; k++) begin
      d0_smp = 2'($urandom); d0_rec = 2'($urandom);
      d1_smp = 2'($urandom); d1_rec = 2'($urandom);
      run_cycle(1'($urandom), 1'($urandom), int'($urandom % 10), w);
      if ($urandom % 2 == 0) idle(int'($urandom % 4));
    end
    idle(10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog %s actual=hung expected=finished", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule